// File: doc/BRIEF.md
# Four-Level Page Table Walker (4 KB granule)

This block translates a 48-bit virtual address into a 48-bit physical address. It reads 64-bit translation descriptors from memory, one level at a time. A request carries the virtual address and the frame number of the top-level table. The walker then issues one descriptor read per level over a valid/ready read port. Each returned descriptor is decoded, and the walker does one of three things:

- it descends into the next table,
- it finishes on a block or page mapping,
- it stops with a fault code and the level at which the walk ended.

The result leaves the block as a single-cycle completion pulse. The pulse carries the physical address and the attribute bits of the final descriptor, or a fault code. The walk can end early at level 1 (a 1 GB block) or at level 2 (a 2 MB block). The meaning of descriptor bit 1 depends on the level. The walker serves one request at a time and keeps at most one descriptor read in flight.

Top module: `xlat_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `done` and `mem_req_valid` are 0. `req_ready` is 1 exactly while no walk is in progress. It drops in the cycle after a request is taken and returns in the cycle that `done` is 1. A request presented while busy is not taken.
- R2: The descriptor read address is {table frame, index, 3'b000}. The index is VA[47:39] at level 0, VA[38:30] at level 1, VA[29:21] at level 2 and VA[20:12] at level 3.
- R3: `mem_req_valid` stays high with a stable address until `mem_req_ready`. No new read is issued until the response to the previous one has arrived.
- R4: A descriptor with bit 0 = 0 ends the walk with fault code 1 (translation) and reports the level where it was read.
- R5: A valid descriptor with bit 1 = 0 at level 0 or at level 3 ends the walk with fault code 2 (bad descriptor type) at that level.
- R6: A valid descriptor with bit 1 = 1 at levels 0 to 2 is a table pointer. Its bits [47:12] become the frame of the table read at the next level.
- R7: A valid descriptor with bit 1 = 0 at level 1 ends the walk with PA = {desc[47:30], VA[29:0]}. At level 2 the PA is {desc[47:21], VA[20:0]}. The fault code is 0.
- R8: A valid descriptor with bit 1 = 1 at level 3 ends the walk with PA = {desc[47:12], VA[11:0]} and fault code 0.
- R9: On success, `done_attr_hi` = desc[63:48] and `done_attr_lo` = desc[11:2] of the final descriptor. On any fault, `done_pa`, `done_attr_hi` and `done_attr_lo` are all zero.
- R10: A response with `mem_rsp_err` = 1 ends the walk with fault code 3 (external abort) at the current level, whatever the returned data holds.
- R11: `done` is a one-cycle pulse in the cycle after the final response. A new request can be taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken when valid |
| req_va | input | 48 | Virtual address to translate |
| req_table_frame | input | 36 | Top-level table base, address bits [47:12] |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 48 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_err | input | 1 | Read ended in error |
| mem_rsp_data | input | 64 | Descriptor value |
| done | output | 1 | Walk finished (one cycle) |
| done_fault | output | 2 | 0 ok, 1 translation, 2 bad type, 3 external abort |
| done_level | output | 2 | Level of the last descriptor read |
| done_pa | output | 48 | Physical address (zero on fault) |
| done_attr_hi | output | 16 | Final descriptor bits [63:48] |
| done_attr_lo | output | 10 | Final descriptor bits [11:2] |

## Verification
The completion pulse and the acceptance of the next request share a cycle. The bench provokes this by chaining walks, presenting the next request while the current one is still in flight. It then checks, against a behavioural model, that `req_ready` returns exactly in the cycle `done` fires and that the held request is taken at that edge. An error response and descriptor data that would otherwise be a valid table pointer also arrive together. The bench returns such a descriptor with the error flag set and expects the abort code to win at that level.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_XLATE = 2'd1,
    FLT_TYPE  = 2'd2,
    FLT_ABORT = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    DK_FAULT,
    DK_TABLE,
    DK_LEAF,
    DK_BADTYPE
  } dkind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } wstate_e;

endpackage

// File: rtl/xlat_fetch.sv
module xlat_fetch #(
  parameter int PA_W       = 48,
  parameter int VA_W       = 48,
  parameter int LEVELS     = 4,
  parameter int IDX_W      = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int LVL_W      = 2
) (
  input  logic [VA_W-1:PAGE_SHIFT] va_hi,
  input  logic [PA_W-1:PAGE_SHIFT] frame,
  input  logic [LVL_W-1:0]         level,
  output logic [PA_W-1:0]          addr
);
  localparam int ENT_B = PAGE_SHIFT - IDX_W;

  logic [IDX_W-1:0] idx_lv [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    localparam int LSB = PAGE_SHIFT + IDX_W * (LEVELS - 1 - g);
    assign idx_lv[g] = va_hi[LSB +: IDX_W];
  end

  assign addr = {frame, idx_lv[level], {ENT_B{1'b0}}};
endmodule

// File: rtl/xlat_decode.sv
module xlat_decode
  import xlat_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int LVL_W  = 2,
  parameter int BLK_LO = 1,
  parameter int BLK_HI = 2
) (
  input  logic [1:0]       desc_lo,
  input  logic [LVL_W-1:0] level,
  output dkind_e           kind
);
  always_comb begin
    if (!desc_lo[0])
      kind = DK_FAULT;
    else if (level == LVL_W'(LEVELS - 1))
      kind = desc_lo[1] ? DK_LEAF : DK_BADTYPE;
    else if (desc_lo[1])
      kind = DK_TABLE;
    else if (level >= LVL_W'(BLK_LO) && level <= LVL_W'(BLK_HI))
      kind = DK_LEAF;
    else
      kind = DK_BADTYPE;
  end
endmodule

// File: rtl/xlat_pa_form.sv
module xlat_pa_form #(
  parameter int PA_W       = 48,
  parameter int VA_W       = 48,
  parameter int DESC_W     = 64,
  parameter int LEVELS     = 4,
  parameter int IDX_W      = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int LVL_W      = 2
) (
  input  logic [DESC_W-1:0]       desc,
  input  logic [VA_W-1:0]         va,
  input  logic [LVL_W-1:0]        level,
  output logic [PA_W-1:0]         pa,
  output logic [DESC_W-PA_W-1:0]  attr_hi,
  output logic [PAGE_SHIFT-3:0]   attr_lo
);
  logic [PA_W-1:0] off_mask [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_mask
    localparam int OFF = PAGE_SHIFT + IDX_W * (LEVELS - 1 - g);
    if (OFF >= PA_W) begin : g_full
      assign off_mask[g] = '1;
    end else begin : g_part
      assign off_mask[g] = (PA_W'(1) << OFF) - PA_W'(1);
    end
  end

  assign pa      = (desc[PA_W-1:0] & ~off_mask[level]) | (va[PA_W-1:0] & off_mask[level]);
  assign attr_hi = desc[DESC_W-1:PA_W];
  assign attr_lo = desc[PAGE_SHIFT-1:2];
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int PA_W       = 48,
  parameter int DESC_W     = 64,
  parameter int LEVELS     = 4,
  parameter int IDX_W      = 9,
  parameter int PAGE_SHIFT = 12,
  parameter int BLK_LO     = 1,
  parameter int BLK_HI     = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VA_W-1:0]          req_va,
  input  logic [PA_W-PAGE_SHIFT-1:0] req_table_frame,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [PA_W-1:0]          mem_req_addr,
  input  logic                     mem_rsp_valid,
  input  logic                     mem_rsp_err,
  input  logic [DESC_W-1:0]        mem_rsp_data,
  output logic                     done,
  output logic [1:0]               done_fault,
  output logic [1:0]               done_level,
  output logic [PA_W-1:0]          done_pa,
  output logic [DESC_W-PA_W-1:0]   done_attr_hi,
  output logic [PAGE_SHIFT-3:0]    done_attr_lo
);
  localparam int LVL_W = $clog2(LEVELS);
  localparam int FR_W  = PA_W - PAGE_SHIFT;

  wstate_e                  st;
  logic [LVL_W-1:0]         lvl;
  logic [VA_W-1:0]          va_q;
  logic [FR_W-1:0]          frame_q;
  logic                     wait_rsp;

  dkind_e                   kind;
  fault_e                   fault_n;
  logic [PA_W-1:0]          pa_n;
  logic [DESC_W-PA_W-1:0]   ahi_n;
  logic [PAGE_SHIFT-3:0]    alo_n;

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_ISSUE);
  assign wait_rsp      = (st == ST_WAIT);

  xlat_fetch #(
    .PA_W(PA_W), .VA_W(VA_W), .LEVELS(LEVELS), .IDX_W(IDX_W),
    .PAGE_SHIFT(PAGE_SHIFT), .LVL_W(LVL_W)
  ) u_fetch (
    .va_hi (va_q[VA_W-1:PAGE_SHIFT]),
    .frame (frame_q),
    .level (lvl),
    .addr  (mem_req_addr)
  );

  xlat_decode #(
    .LEVELS(LEVELS), .LVL_W(LVL_W), .BLK_LO(BLK_LO), .BLK_HI(BLK_HI)
  ) u_dec (
    .desc_lo (mem_rsp_data[1:0]),
    .level   (lvl),
    .kind    (kind)
  );

  xlat_pa_form #(
    .PA_W(PA_W), .VA_W(VA_W), .DESC_W(DESC_W), .LEVELS(LEVELS),
    .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT), .LVL_W(LVL_W)
  ) u_pa (
    .desc    (mem_rsp_data),
    .va      (va_q),
    .level   (lvl),
    .pa      (pa_n),
    .attr_hi (ahi_n),
    .attr_lo (alo_n)
  );

  always_comb begin
    if (mem_rsp_err)
      fault_n = FLT_ABORT;
    else begin
      case (kind)
        DK_FAULT:   fault_n = FLT_XLATE;
        DK_BADTYPE: fault_n = FLT_TYPE;
        default:    fault_n = FLT_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      lvl          <= '0;
      va_q         <= '0;
      frame_q      <= '0;
      done         <= 1'b0;
      done_fault   <= '0;
      done_level   <= '0;
      done_pa      <= '0;
      done_attr_hi <= '0;
      done_attr_lo <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            va_q    <= req_va;
            frame_q <= req_table_frame;
            lvl     <= '0;
            st      <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (!mem_rsp_err && kind == DK_TABLE) begin
              frame_q <= mem_rsp_data[PA_W-1:PAGE_SHIFT];
              lvl     <= lvl + LVL_W'(1);
              st      <= ST_ISSUE;
            end else begin
              st         <= ST_IDLE;
              done       <= 1'b1;
              done_fault <= fault_n;
              done_level <= 2'(lvl);
              if (fault_n == FLT_NONE) begin
                done_pa      <= pa_n;
                done_attr_hi <= ahi_n;
                done_attr_lo <= alo_n;
              end else begin
                done_pa      <= '0;
                done_attr_hi <= '0;
                done_attr_lo <= '0;
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
  parameter int PA_W = 48,
  parameter int AH_W = 16,
  parameter int AL_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            mem_rsp_err,
  input logic            waiting,
  input logic            done,
  input logic [1:0]      done_fault,
  input logic [PA_W-1:0] done_pa,
  input logic [AH_W-1:0] done_attr_hi,
  input logic [AL_W-1:0] done_attr_lo
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready && mem_req_valid); // R1

  AST_ISSUE_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R3

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (rst)
    waiting |-> !mem_req_valid); // R3

  AST_ABORT_WINS: assert property (@(posedge clk) disable iff (rst)
    waiting && mem_rsp_valid && mem_rsp_err |=> done && done_fault == 2'd3); // R10

  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    done && done_fault != 2'd0 |-> done_pa == '0 && done_attr_hi == '0 && done_attr_lo == '0); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready); // R11

  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(waiting && mem_rsp_valid)); // R11
endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_err   (mem_rsp_err),
  .waiting       (wait_rsp),
  .done          (done),
  .done_fault    (done_fault),
  .done_pa       (done_pa),
  .done_attr_hi  (done_attr_hi),
  .done_attr_lo  (done_attr_lo)
);

// File: tb/xlat_walker_test.sv
`timescale 1ns/1ps
module xlat_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_va = '0;
  logic [35:0] req_table_frame = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_err = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic [1:0]  done_fault;
  logic [1:0]  done_level;
  logic [47:0] done_pa;
  logic [15:0] done_attr_hi;
  logic [9:0]  done_attr_lo;

  always #2 clk = ~clk;

  xlat_walker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_table_frame(req_table_frame),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .done(done), .done_fault(done_fault), .done_level(done_level),
    .done_pa(done_pa), .done_attr_hi(done_attr_hi), .done_attr_lo(done_attr_lo)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  localparam int K_XL = 1, K_TY = 2, K_AB = 3, K_BLK = 4, K_PG = 5;

  function automatic string tag(int k);
    case (k)
      K_XL:    return "R4 translation fault";
      K_TY:    return "R5 bad type";
      K_AB:    return "R10 abort";
      K_BLK:   return "R7 block";
      default: return "R8 page";
    endcase
  endfunction

  typedef struct {
    logic [1:0]  fc;
    logic [1:0]  lv;
    logic [47:0] pa;
    logic [15:0] ah;
    logic [9:0]  al;
    int          nreads;
    int          kind;
  } exp_t;

  logic [63:0] tbl [logic [47:0]];
  bit          abort_at [logic [47:0]];
  exp_t        exp_q [$];
  logic [47:0] addr_q [$];

  function automatic logic [47:0] ea(logic [35:0] fr, logic [47:0] va, int l);
    return {fr, va[12 + 9*(3-l) +: 9], 3'b000};
  endfunction

  function automatic logic [47:0] mkva(int i0, int i1, int i2, int i3, logic [11:0] off);
    return {i0[8:0], i1[8:0], i2[8:0], i3[8:0], off};
  endfunction

  function automatic logic [63:0] tdesc(logic [35:0] fr);
    return {16'h0, fr, 10'h0, 2'b11};
  endfunction

  function automatic logic [63:0] leaf(logic [15:0] hi, logic [47:0] o, logic [9:0] lo, bit t1);
    return {hi, o[47:12], lo, t1, 1'b1};
  endfunction

  // Behavioural walk: pushes expected read addresses and returns the outcome
  function automatic exp_t ref_walk(logic [47:0] va, logic [35:0] fr);
    exp_t e;
    logic [47:0] tb;
    logic [47:0] a;
    logic [63:0] d;
    logic [47:0] m;
    e = '{fc: 2'd0, lv: 2'd0, pa: '0, ah: '0, al: '0, nreads: 0, kind: 0};
    tb = {fr, 12'h0};
    for (int l = 0; l < 4; l++) begin
      a = {tb[47:12], va[12 + 9*(3-l) +: 9], 3'b000};
      addr_q.push_back(a);
      e.nreads++;
      e.lv = 2'(l);
      if (abort_at.exists(a)) begin e.fc = 2'd3; e.kind = K_AB; return e; end
      d = tbl.exists(a) ? tbl[a] : 64'h0;
      if (!d[0]) begin e.fc = 2'd1; e.kind = K_XL; return e; end
      if (d[1] && l < 3) begin tb = {d[47:12], 12'h0}; continue; end
      if (!d[1] && (l == 0 || l == 3)) begin e.fc = 2'd2; e.kind = K_TY; return e; end
      m = (48'h1 << (12 + 9*(3-l))) - 48'h1;
      e.pa = (d[47:0] & ~m) | (va & m);
      e.ah = d[63:48];
      e.al = d[11:2];
      e.kind = (l == 3) ? K_PG : K_BLK;
      return e;
    end
    return e;
  endfunction

  // Cycle model: busy flag, read bookkeeping, memory responder
  bit          busy = 1'b0;
  bit          done_due = 1'b0;
  bit          pend = 1'b0;
  int          lat = 0;
  int          reads_left = 0;
  logic [47:0] pend_addr = '0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) begin
    if (rst) begin
      busy = 1'b0; done_due = 1'b0; pend = 1'b0;
    end else begin
      done_due = 1'b0;
      if (req_valid && req_ready) begin
        exp_t e;
        e = ref_walk(req_va, req_table_frame);
        exp_q.push_back(e);
        reads_left = e.nreads;
        busy = 1'b1;
      end
      if (mem_req_valid && mem_req_ready) begin
        chk("R3 single outstanding read", 64'(pend), 64'd0);
        if (addr_q.size() == 0) chk("R2/R6 unexpected read", 64'(mem_req_addr), 64'hFFFF);
        else chk("R2/R6 read address", 64'(mem_req_addr), 64'(addr_q.pop_front()));
        pend = 1'b1;
        pend_addr = mem_req_addr;
        lat = int'(lfsr[1:0]);
      end
      if (mem_rsp_valid) begin
        reads_left--;
        if (reads_left == 0) begin done_due = 1'b1; busy = 1'b0; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R1 ready tracks idle", 64'(req_ready), 64'(!busy));
      chk("R11 done timing", 64'(done), 64'(done_due));
      if (done) begin
        if (exp_q.size() == 0) chk("R11 spurious done", 64'd1, 64'd0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(tag(e.kind), 64'(done_fault), 64'(e.fc));
          chk(tag(e.kind), 64'(done_level), 64'(e.lv));
          chk(tag(e.kind), 64'(done_pa), 64'(e.pa));
          chk("R9 attr hi", 64'(done_attr_hi), 64'(e.ah));
          chk("R9 attr lo", 64'(done_attr_lo), 64'(e.al));
        end
      end
    end
    mem_rsp_valid = 1'b0;
    mem_rsp_err = 1'b0;
    if (pend) begin
      if (lat == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = tbl.exists(pend_addr) ? tbl[pend_addr] : 64'h0;
        mem_rsp_err = abort_at.exists(pend_addr);
        pend = 1'b0;
      end else lat--;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready = lfsr[0] | lfsr[3];
  end

  task automatic send(logic [47:0] va, logic [35:0] fr);
    @(negedge clk);
    req_valid = 1'b1;
    req_va = va;
    req_table_frame = fr;
    forever begin
      @(posedge clk);
      if (req_ready) break;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run(logic [47:0] va, logic [35:0] fr);
    send(va, fr);
    while (exp_q.size() != 0 || busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [35:0] FR_R = 36'h00100, FR_1 = 36'h00200, FR_2 = 36'h00300;
  localparam logic [35:0] FR_3 = 36'h00400, FR_1B = 36'h00210, FR_2C = 36'h00310;
  localparam logic [35:0] FR_1G = 36'h00220;

  logic [47:0] va_a, va_b, va_c, va_d, va_e, va_f, va_g, va_h;

  initial begin
    va_a = mkva(1, 2, 3, 4, 12'hABC);
    va_b = mkva(5, 7, 9'h1AB, 9'h0CD, 12'h321);
    va_c = mkva(1, 8, 17, 33, 12'h777);
    va_d = mkva(9, 1, 1, 1, 12'h010);
    va_e = mkva(10, 0, 0, 0, 12'h0);
    va_f = mkva(1, 2, 3, 6, 12'h5A5);
    va_g = mkva(11, 4, 0, 0, 12'h0);
    va_h = mkva(1, 2, 5, 0, 12'h0);

    tbl[ea(FR_R, va_a, 0)] = tdesc(FR_1);
    tbl[ea(FR_1, va_a, 1)] = tdesc(FR_2);
    tbl[ea(FR_2, va_a, 2)] = tdesc(FR_3);
    tbl[ea(FR_3, va_a, 3)] = leaf(16'h1234, 48'h0008_1234_5000, 10'h155, 1'b1);
    tbl[ea(FR_R, va_b, 0)] = tdesc(FR_1B);
    tbl[ea(FR_1B, va_b, 1)] = leaf(16'h0040, 48'h00C0_1234_5000, 10'h2AA, 1'b0);
    tbl[ea(FR_1, va_c, 1)] = tdesc(FR_2C);
    tbl[ea(FR_2C, va_c, 2)] = leaf(16'h8001, 48'h0007_E03F_F000, 10'h0F0, 1'b0);
    tbl[ea(FR_R, va_e, 0)] = leaf(16'h0, 48'h0001_0000_0000, 10'h0, 1'b0);
    tbl[ea(FR_3, va_f, 3)] = leaf(16'hFFFF, 48'h0000_0000_7000, 10'h3FF, 1'b0);
    tbl[ea(FR_R, va_g, 0)] = tdesc(FR_1G);
    tbl[ea(FR_1G, va_g, 1)] = tdesc(FR_2);
    abort_at[ea(FR_1G, va_g, 1)] = 1'b1;
    tbl[ea(FR_2, va_h, 2)] = 64'hFFFF_0000_0000_F000;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 reset ready", 64'(req_ready), 64'd1);
    chk("R1 reset done", 64'(done), 64'd0);
    chk("R1 reset mem_req_valid", 64'(mem_req_valid), 64'd0);

    run(va_a, FR_R);                       // R8 four-level page
    run(va_b, FR_R);                       // R7 1 GB block
    run(va_c, FR_R);                       // R7 2 MB block
    run(va_d, FR_R);                       // R4 fault at level 0
    run(va_h, FR_R);                       // R4 fault at level 2, R9 zeroed outputs
    run(va_e, FR_R);                       // R5 block encoding at level 0
    run(va_f, FR_R);                       // R5 block encoding at level 3
    run(va_g, FR_R);                       // R10 error beats valid table data
    run(mkva(1, 2, 3, 4, 12'h000), FR_R);  // R8 offset low edge
    run(mkva(1, 2, 3, 4, 12'hFFF), FR_R);  // R8 offset high edge

    // R11: chained requests held while busy, taken in the done cycle
    send(va_a, FR_R);
    send(va_b, FR_R);
    send(va_c, FR_R);
    send(va_f, FR_R);
    run(va_g, FR_R);

    for (int i = 0; i < 24; i++) begin
      case (i % 8)
        0: send(va_a, FR_R);
        1: send(va_b, FR_R);
        2: send(va_c, FR_R);
        3: send(va_d, FR_R);
        4: send(va_e, FR_R);
        5: send(va_f, FR_R);
        6: send(va_g, FR_R);
        default: run(va_h, FR_R);
      endcase
    end
    while (exp_q.size() != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule